// File: doc/BRIEF.md
# Decode Operand Forwarding Select

This block sits in the decode stage of a five-stage in-order processor pipeline. It supplies the two source operand values for the instruction being decoded. Each operand is taken from the register file unless a newer value for the same register is still on its way down the pipeline. In that case the newest such value is used, so the program sees the same results it would see if its instructions ran one at a time.

Five in-flight results can be forwarded:

- the ALU result being computed in the execute stage during this cycle;
- the data read from memory and the ALU result, both held in the memory-stage pipeline register;
- the memory read data and the ALU result held in the write-back pipeline register.

Register ID 0xF means "no register" on either side of the comparison, so it never produces a match. A conditional move whose condition fails is given destination 0xF upstream, and as a result it never forwards.

For call and jump instructions, operand A carries the incremented PC from decode instead of any register value. Stalling for a load whose data is not yet ready is handled by the pipeline control logic, not by this block.

Top module: `opfwd_select`

## Requirements
- R1: A source register ID of 0xF matches no destination. That operand is then the register-file read data for its port, except in the call/jump case of R2.
- R2: When `dec_pc_op` is 1, `opnd_a` equals `dec_valp`, whatever the register IDs and in-flight values are.
- R3: When a source ID is not 0xF and equals none of the five destination IDs, the operand is the register-file read data for its port.
- R4: A source ID (not 0xF) that equals `ex_dst_e` yields `ex_vale`, even when later stages also match.
- R5: If execute does not match, a match on `mem_dst_m` yields `mem_valm`. Only when that also fails does a match on `mem_dst_e` yield `mem_vale`. Either of these takes precedence over any write-back match.
- R6: If execute and memory do not match, a match on `wb_dst_m` yields `wb_valm`. Only when that also fails does a match on `wb_dst_e` yield `wb_vale`. Either of these takes precedence over the register file.
- R7: Operand B selects using `dec_src_b` alone and is never affected by `dec_pc_op`. Operand A selects using `dec_src_a` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_pc_op | input | 1 | Decoded instruction is a call or jump |
| dec_valp | input | DATA_W | Incremented PC computed in decode |
| dec_src_a | input | 4 | Source register ID for operand A (0xF = none) |
| dec_src_b | input | 4 | Source register ID for operand B (0xF = none) |
| rf_rdata_a | input | DATA_W | Register file read data, port A |
| rf_rdata_b | input | DATA_W | Register file read data, port B |
| ex_dst_e | input | 4 | Execute-stage ALU destination ID |
| ex_vale | input | DATA_W | ALU result being computed in execute |
| mem_dst_m | input | 4 | Memory-stage load destination ID |
| mem_valm | input | DATA_W | Data read from memory in the memory stage |
| mem_dst_e | input | 4 | Memory-stage ALU destination ID |
| mem_vale | input | DATA_W | ALU result held in the memory stage |
| wb_dst_m | input | 4 | Write-back load destination ID |
| wb_valm | input | DATA_W | Load data held in the write-back stage |
| wb_dst_e | input | 4 | Write-back ALU destination ID |
| wb_vale | input | DATA_W | ALU result held in the write-back stage |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
Some properties are checked by assertions on every evaluation:

- the incremented-PC override on operand A;
- the "no register" source on both operands;
- execute winning whenever it matches;
- the memory load value beating the memory ALU value;
- the register-file fallback when nothing matches.

The complete five-level priority needs the bench's sweep to show it. The sweep places every destination on the operand's own register, on the other operand's register, or on 0xF. Only that sweep shows the write-back ordering, the behaviour when several stages match at once, and that each operand ignores matches meant for the other one.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned REG_ID_W = 4;
  localparam logic [REG_ID_W-1:0] REG_NONE = 4'hF;
  // Number of in-flight forwarding sources, index 0 = highest priority
  localparam int unsigned NUM_FWD = 5;
  typedef enum logic [2:0] {
    FWD_EX_E  = 3'd0,
    FWD_MEM_M = 3'd1,
    FWD_MEM_E = 3'd2,
    FWD_WB_M  = 3'd3,
    FWD_WB_E  = 3'd4
  } fwd_src_e;
endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect
  import fwd_pkg::*;
#(
  parameter int unsigned NSRC = NUM_FWD
) (
  input  logic [REG_ID_W-1:0]           src_id,
  input  logic [NSRC-1:0][REG_ID_W-1:0] dst_ids,
  output logic [NSRC-1:0]               hit
);
  logic src_valid;
  assign src_valid = (src_id != REG_NONE);

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_cmp
    assign hit[gi] = src_valid && (dst_ids[gi] != REG_NONE) && (dst_ids[gi] == src_id);
  end
endmodule

// File: rtl/fwd_prio_mux.sv
module fwd_prio_mux #(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned DATA_W = 64
) (
  input  logic [NSRC-1:0]             hit,
  input  logic [NSRC-1:0][DATA_W-1:0] vals,
  input  logic [DATA_W-1:0]           fallback,
  output logic [DATA_W-1:0]           dout
);
  // Scan from lowest priority upward so index 0 overrides all others
  always_comb begin
    dout = fallback;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i]) dout = vals[i];
    end
  end
endmodule

// File: rtl/opfwd_select.sv
module opfwd_select
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                dec_pc_op,
  input  logic [DATA_W-1:0]   dec_valp,
  input  logic [REG_ID_W-1:0] dec_src_a,
  input  logic [REG_ID_W-1:0] dec_src_b,
  input  logic [DATA_W-1:0]   rf_rdata_a,
  input  logic [DATA_W-1:0]   rf_rdata_b,
  input  logic [REG_ID_W-1:0] ex_dst_e,
  input  logic [DATA_W-1:0]   ex_vale,
  input  logic [REG_ID_W-1:0] mem_dst_m,
  input  logic [DATA_W-1:0]   mem_valm,
  input  logic [REG_ID_W-1:0] mem_dst_e,
  input  logic [DATA_W-1:0]   mem_vale,
  input  logic [REG_ID_W-1:0] wb_dst_m,
  input  logic [DATA_W-1:0]   wb_valm,
  input  logic [REG_ID_W-1:0] wb_dst_e,
  input  logic [DATA_W-1:0]   wb_vale,
  output logic [DATA_W-1:0]   opnd_a,
  output logic [DATA_W-1:0]   opnd_b
);
  localparam int unsigned NOPND = 2;

  logic [NUM_FWD-1:0][REG_ID_W-1:0] dst_vec;
  logic [NUM_FWD-1:0][DATA_W-1:0]   val_vec;
  logic [NOPND-1:0][REG_ID_W-1:0]   src_vec;
  logic [NOPND-1:0][DATA_W-1:0]     rf_vec;
  logic [NOPND-1:0][DATA_W-1:0]     fwd_out;

  // Priority order: youngest producer first
  always_comb begin
    dst_vec[FWD_EX_E]  = ex_dst_e;   val_vec[FWD_EX_E]  = ex_vale;
    dst_vec[FWD_MEM_M] = mem_dst_m;  val_vec[FWD_MEM_M] = mem_valm;
    dst_vec[FWD_MEM_E] = mem_dst_e;  val_vec[FWD_MEM_E] = mem_vale;
    dst_vec[FWD_WB_M]  = wb_dst_m;   val_vec[FWD_WB_M]  = wb_valm;
    dst_vec[FWD_WB_E]  = wb_dst_e;   val_vec[FWD_WB_E]  = wb_vale;
  end

  assign src_vec[0] = dec_src_a;
  assign src_vec[1] = dec_src_b;
  assign rf_vec[0]  = rf_rdata_a;
  assign rf_vec[1]  = rf_rdata_b;

  for (genvar go = 0; go < NOPND; go++) begin : g_opnd
    logic [NUM_FWD-1:0] hit;

    fwd_hit_detect #(.NSRC(NUM_FWD)) u_hit (
      .src_id  (src_vec[go]),
      .dst_ids (dst_vec),
      .hit     (hit)
    );

    fwd_prio_mux #(.NSRC(NUM_FWD), .DATA_W(DATA_W)) u_mux (
      .hit      (hit),
      .vals     (val_vec),
      .fallback (rf_vec[go]),
      .dout     (fwd_out[go])
    );
  end

  // Call/jump: incremented PC replaces any register value on operand A
  assign opnd_a = dec_pc_op ? dec_valp : fwd_out[0];
  assign opnd_b = fwd_out[1];
endmodule

// File: rtl/opfwd_select_chk.sv
module opfwd_select_chk
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input logic                dec_pc_op,
  input logic [DATA_W-1:0]   dec_valp,
  input logic [REG_ID_W-1:0] dec_src_a,
  input logic [REG_ID_W-1:0] dec_src_b,
  input logic [DATA_W-1:0]   rf_rdata_a,
  input logic [DATA_W-1:0]   rf_rdata_b,
  input logic [REG_ID_W-1:0] ex_dst_e,
  input logic [DATA_W-1:0]   ex_vale,
  input logic [REG_ID_W-1:0] mem_dst_m,
  input logic [DATA_W-1:0]   mem_valm,
  input logic [REG_ID_W-1:0] mem_dst_e,
  input logic [DATA_W-1:0]   mem_vale,
  input logic [REG_ID_W-1:0] wb_dst_m,
  input logic [DATA_W-1:0]   wb_valm,
  input logic [REG_ID_W-1:0] wb_dst_e,
  input logic [DATA_W-1:0]   wb_vale,
  input logic [DATA_W-1:0]   opnd_a,
  input logic [DATA_W-1:0]   opnd_b
);
  logic b_any_match;
  assign b_any_match = (dec_src_b == ex_dst_e) || (dec_src_b == mem_dst_m) ||
                       (dec_src_b == mem_dst_e) || (dec_src_b == wb_dst_m) ||
                       (dec_src_b == wb_dst_e);

  always_comb begin
    if (dec_pc_op)
      AST_PC_OVERRIDES_A: assert (opnd_a == dec_valp) else $error("pc override"); // R2
    if (!dec_pc_op && dec_src_a == REG_NONE)
      AST_NONE_SRC_A: assert (opnd_a == rf_rdata_a) else $error("none src a"); // R1
    if (dec_src_b == REG_NONE)
      AST_NONE_SRC_B: assert (opnd_b == rf_rdata_b) else $error("none src b"); // R1
    if (dec_src_b != REG_NONE && !b_any_match)
      AST_RF_FALLBACK_B: assert (opnd_b == rf_rdata_b) else $error("rf fallback"); // R3
    if (dec_src_b != REG_NONE && dec_src_b == ex_dst_e)
      AST_EX_WINS_B: assert (opnd_b == ex_vale) else $error("ex priority"); // R4
    if (dec_src_b != REG_NONE && dec_src_b != ex_dst_e && dec_src_b == mem_dst_m)
      AST_MEM_LOAD_WINS_B: assert (opnd_b == mem_valm) else $error("mem priority"); // R5
  end

  logic unused_ok;
  assign unused_ok = ^{mem_vale, wb_valm, wb_vale};
endmodule

bind opfwd_select opfwd_select_chk #(.DATA_W(DATA_W)) u_chk (
  .dec_pc_op  (dec_pc_op),
  .dec_valp   (dec_valp),
  .dec_src_a  (dec_src_a),
  .dec_src_b  (dec_src_b),
  .rf_rdata_a (rf_rdata_a),
  .rf_rdata_b (rf_rdata_b),
  .ex_dst_e   (ex_dst_e),
  .ex_vale    (ex_vale),
  .mem_dst_m  (mem_dst_m),
  .mem_valm   (mem_valm),
  .mem_dst_e  (mem_dst_e),
  .mem_vale   (mem_vale),
  .wb_dst_m   (wb_dst_m),
  .wb_valm    (wb_valm),
  .wb_dst_e   (wb_dst_e),
  .wb_vale    (wb_vale),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b)
);

// File: tb/opfwd_select_tb.sv
module opfwd_select_tb;
  localparam int DW = 64;
  localparam logic [3:0] NONE = 4'hF;

  logic clk;
  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic          dec_pc_op;
  logic [DW-1:0] dec_valp, rf_rdata_a, rf_rdata_b;
  logic [3:0]    dec_src_a, dec_src_b;
  logic [3:0]    ex_dst_e, mem_dst_m, mem_dst_e, wb_dst_m, wb_dst_e;
  logic [DW-1:0] ex_vale, mem_valm, mem_vale, wb_valm, wb_vale;
  logic [DW-1:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  opfwd_select #(.DATA_W(DW)) u_dut (
    .dec_pc_op(dec_pc_op), .dec_valp(dec_valp),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .ex_dst_e(ex_dst_e), .ex_vale(ex_vale),
    .mem_dst_m(mem_dst_m), .mem_valm(mem_valm),
    .mem_dst_e(mem_dst_e), .mem_vale(mem_vale),
    .wb_dst_m(wb_dst_m), .wb_valm(wb_valm),
    .wb_dst_e(wb_dst_e), .wb_vale(wb_vale),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Reference: walk the stages youngest first (R4, R5, R6), else register file (R1, R3)
  function automatic void model(input logic [3:0] src, input logic [DW-1:0] rf,
                                output logic [DW-1:0] val, output string tag);
    logic [3:0]    d [5];
    logic [DW-1:0] v [5];
    string         t [5];
    d = '{ex_dst_e, mem_dst_m, mem_dst_e, wb_dst_m, wb_dst_e};
    v = '{ex_vale, mem_valm, mem_vale, wb_valm, wb_vale};
    t = '{"R4", "R5", "R5", "R6", "R6"};
    val = rf;
    tag = (src == NONE) ? "R1" : "R3";
    if (src != NONE) begin
      for (int k = 0; k < 5; k++) begin
        if (d[k] == src) begin
          val = v[k];
          tag = t[k];
          break;
        end
      end
    end
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    logic [DW-1:0] ea, eb;
    string ta, tb;
    // Fixed, distinct values per source
    dec_valp   = 64'hC0DE_0000_0000_0A0A;
    rf_rdata_a = 64'hAAAA_0000_0000_0001;
    rf_rdata_b = 64'hBBBB_0000_0000_0002;
    ex_vale    = 64'h1111_0000_0000_0003;
    mem_valm   = 64'h2222_0000_0000_0004;
    mem_vale   = 64'h3333_0000_0000_0005;
    wb_valm    = 64'h4444_0000_0000_0006;
    wb_vale    = 64'h5555_0000_0000_0007;
    dec_pc_op = 1'b0;
    dec_src_a = NONE; dec_src_b = NONE;
    ex_dst_e = NONE; mem_dst_m = NONE; mem_dst_e = NONE; wb_dst_m = NONE; wb_dst_e = NONE;

    // Idle state: nothing in flight, both operands come from the register file
    @(posedge clk); @(negedge clk);
    check("R1 idle a", opnd_a, rf_rdata_a);
    check("R1 idle b", opnd_b, rf_rdata_b);

    // Sweep: each destination is on the A register, on the B register, or 0xF
    for (int s = 0; s < 16; s++) begin
      for (int combo = 0; combo < 243; combo++) begin
        for (int pc = 0; pc < 2; pc++) begin
          logic [3:0] opt [3];
          int c;
          @(posedge clk);
          dec_src_a = 4'(s);
          dec_src_b = 4'((s + 5) % 16);
          opt = '{dec_src_a, dec_src_b, NONE};
          c = combo;
          ex_dst_e  = opt[c % 3]; c = c / 3;
          mem_dst_m = opt[c % 3]; c = c / 3;
          mem_dst_e = opt[c % 3]; c = c / 3;
          wb_dst_m  = opt[c % 3]; c = c / 3;
          wb_dst_e  = opt[c % 3];
          dec_pc_op = pc[0];
          @(negedge clk);
          model(dec_src_a, rf_rdata_a, ea, ta);
          model(dec_src_b, rf_rdata_b, eb, tb);
          if (dec_pc_op) begin
            check("R2 operand a", opnd_a, dec_valp);
            check({"R7 operand b / ", tb}, opnd_b, eb);
          end else begin
            check({ta, " operand a"}, opnd_a, ea);
            check({tb, " operand b"}, opnd_b, eb);
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule